// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a frame stored in memory and issues the read burst requests that bring it in, one display line after another. A start-of-frame pulse captures the frame's base byte address, the number of bytes to fetch per line, the byte distance between successive line starts and the number of lines minus one. It then emits bursts of 8-byte beats on a valid/ready request channel. Because the fetch length and the line stride are programmed separately, a frame can be cropped out of a wider surface.

Each line is cut into bursts no longer than the configured maximum. The final burst of a line carries only the beats still needed. A separate limit caps how many requests may be in flight at once, and a response-done pulse retires one of them. When the last burst of the last line has been accepted, the generator stays idle until the next start-of-frame pulse. Burst and in-flight limits are read live. The frame geometry and the base address are captured only at the start of a frame.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset, `req_valid` is low and no request is in flight.
- R2: The first request after a start-of-frame pulse carries the address that `cfg_base` held when the pulse was taken.
- R3: One beat is 8 bytes. Each request carries at least 1 beat and at most the effective burst limit. A `cfg_burst` of 0 acts as 1, and a value above 16 acts as 16.
- R4: A line needs ceil(`cfg_line_bytes`/8) beats. Bursts within a line are contiguous. The last burst of a line carries only the remaining beats.
- R5: Each line starts `cfg_pitch` bytes after the start of the previous line, whatever the line length.
- R6: Exactly `cfg_lines_m1`+1 lines are fetched. After that, `req_valid` stays low until the next start-of-frame pulse.
- R7: No new request is raised while the in-flight count equals `cfg_outstanding` (0 acts as 1). Each `rsp_done` pulse lowers the count by one.
- R8: A change of `cfg_base` during a frame has no effect on that frame. It is used at the next start-of-frame pulse.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_beats` hold their values, even if `cfg_burst` changes.
- R10: A start-of-frame pulse that arrives while a request is stalled is kept. The stalled request completes first, and the walk then restarts from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Byte address of the frame's first pixel |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Byte step between line starts |
| cfg_lines_m1 | input | LINE_W | Number of lines minus one |
| cfg_burst | input | BL_W | Maximum beats per request |
| cfg_outstanding | input | OUT_W | Maximum requests in flight |
| sof | input | 1 | Start-of-frame pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | ADDR_W | Burst start byte address |
| req_beats | output | BL_W | Burst length in beats |
| rsp_done | input | 1 | One in-flight request has completed |

## Verification
The assertions assume a few things about the inputs. `cfg_line_bytes` is nonzero. `rsp_done` never pulses when nothing is in flight. Frame geometry is captured at a start-of-frame pulse, so it need only be valid then. The bench keeps within these limits: every line length is positive, and its responder pulses `rsp_done` only while its own count of accepted, unretired requests is above zero. The stall and reconfiguration scenarios change `cfg_base` and `cfg_burst` deliberately, which stresses the hold rule without breaking these assumptions.

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int LINE_W    = 12,
  parameter int OUT_W     = 4,
  parameter int BEAT_LG2  = 3,
  parameter int MAX_BURST = 16,
  localparam int BL_W     = $clog2(MAX_BURST + 1),
  localparam int BEAT_W   = LEN_W - BEAT_LG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_line_bytes,
  input  logic [LEN_W-1:0]  cfg_pitch,
  input  logic [LINE_W-1:0] cfg_lines_m1,
  input  logic [BL_W-1:0]   cfg_burst,
  input  logic [OUT_W-1:0]  cfg_outstanding,
  input  logic              sof,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BL_W-1:0]   req_beats,
  input  logic              rsp_done
);

  logic              active, hold_q, restart_pend;
  logic [ADDR_W-1:0] line_addr, cur_addr;
  logic [BEAT_W-1:0] rem, line_beats_q;
  logic [LEN_W-1:0]  pitch_q;
  logic [LINE_W-1:0] lines_q, line_idx;
  logic [OUT_W-1:0]  inflight;
  logic [BL_W-1:0]   beats_q;

  logic [BEAT_W-1:0] cfg_beats;
  logic [BL_W-1:0]   burst_eff, fresh_beats;
  logic [OUT_W-1:0]  omax_eff;
  logic              room, accept, stall, do_start, line_end, frame_end, retire;

  assign cfg_beats   = BEAT_W'(({1'b0, cfg_line_bytes} + (LEN_W+1)'(2**BEAT_LG2 - 1)) >> BEAT_LG2);
  assign burst_eff   = (cfg_burst == '0) ? BL_W'(1)
                     : (cfg_burst > BL_W'(MAX_BURST)) ? BL_W'(MAX_BURST) : cfg_burst;
  assign omax_eff    = (cfg_outstanding == '0) ? OUT_W'(1) : cfg_outstanding;
  assign fresh_beats = (rem < BEAT_W'(burst_eff)) ? BL_W'(rem) : burst_eff;
  assign room        = inflight < omax_eff;

  assign req_valid = active & (hold_q | room);
  assign req_beats = hold_q ? beats_q : fresh_beats;
  assign req_addr  = cur_addr;

  assign accept    = req_valid & req_ready;
  assign stall     = req_valid & ~req_ready;
  assign do_start  = (sof | restart_pend) & ~stall;
  assign line_end  = BEAT_W'(req_beats) == rem;
  assign frame_end = line_end & (line_idx == lines_q);
  assign retire    = rsp_done & (inflight != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      hold_q       <= 1'b0;
      restart_pend <= 1'b0;
      inflight     <= '0;
      beats_q      <= '0;
      line_addr    <= '0;
      cur_addr     <= '0;
      rem          <= '0;
      line_beats_q <= '0;
      pitch_q      <= '0;
      lines_q      <= '0;
      line_idx     <= '0;
    end else begin
      hold_q   <= stall;
      beats_q  <= req_beats;
      inflight <= inflight + OUT_W'(accept) - OUT_W'(retire);

      if (do_start)  restart_pend <= 1'b0;
      else if (sof)  restart_pend <= 1'b1;

      if (do_start) begin
        active       <= 1'b1;
        line_addr    <= cfg_base;
        cur_addr     <= cfg_base;
        rem          <= cfg_beats;
        line_beats_q <= cfg_beats;
        pitch_q      <= cfg_pitch;
        lines_q      <= cfg_lines_m1;
        line_idx     <= '0;
      end else if (accept) begin
        if (frame_end) begin
          active <= 1'b0;
        end else if (line_end) begin
          line_idx  <= line_idx + 1'b1;
          line_addr <= line_addr + ADDR_W'(pitch_q);
          cur_addr  <= line_addr + ADDR_W'(pitch_q);
          rem       <= line_beats_q;
        end else begin
          cur_addr <= cur_addr + (ADDR_W'(req_beats) << BEAT_LG2);
          rem      <= rem - BEAT_W'(req_beats);
        end
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats));

  // R3
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hold_q |-> req_beats != '0 && req_beats <= burst_eff);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> inflight < omax_eff);

  // R6
  frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && frame_end && !do_start && !sof |=> !req_valid);

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> req_addr == $past(cfg_base));

endmodule

// File: tb/scanout_addr_gen_tb.sv
`timescale 1ns/1ps
module scanout_addr_gen_tb;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 0;
  logic [15:0] cfg_line_bytes = 8, cfg_pitch = 0;
  logic [11:0] cfg_lines_m1 = 0;
  logic [4:0]  cfg_burst = 4;
  logic [3:0]  cfg_outstanding = 4;
  logic        sof = 0, req_ready = 1, rsp_done = 0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;

  scanout_addr_gen u_dut (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int got_n = 0, bout = 0, peak = 0, exp_n = 0;
  bit resp_en = 1;
  logic [31:0] got_addr [0:255];
  logic [4:0]  got_beats[0:255];
  logic [31:0] exp_addr [0:255];
  logic [4:0]  exp_beats[0:255];

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (req_valid && req_ready && got_n < 256) begin
        got_addr[got_n] = req_addr; got_beats[got_n] = req_beats; got_n++;
      end
      bout = bout + ((req_valid && req_ready) ? 1 : 0) - (rsp_done ? 1 : 0);
      if (bout > peak) peak = bout;
    end
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual cycles=%0d expected <150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1 rsp_done = resp_en && (bout > 0);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sof();
    @(posedge clk); #1 sof = 1;
    @(posedge clk); #1 sof = 0;
  endtask

  task automatic build(input logic [31:0] base, input int len, input int pitch,
                       input int lm1, input int bm);
    int beff = (bm == 0) ? 1 : (bm > 16 ? 16 : bm);
    exp_n = 0;
    for (int l = 0; l <= lm1; l++) begin
      logic [31:0] a = base + l * pitch;
      int r = (len + 7) / 8;
      while (r > 0) begin
        int b = (r < beff) ? r : beff;
        exp_addr[exp_n] = a; exp_beats[exp_n] = 5'(b); exp_n++;
        a += b * 8; r -= b;
      end
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < 3000 && got_n < n; i++) tick(1);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(got_n == exp_n, {req, " burst count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && (got_addr[i] != exp_addr[i] || got_beats[i] != exp_beats[i])) bad = i;
    if (bad >= 0) chk(0, {req, " burst list"}, {got_addr[bad], 3'b0, got_beats[bad]},
                      {exp_addr[bad], 3'b0, exp_beats[bad]});
    else chk(1, req, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && (bout != 0 || req_valid); i++) tick(1);
    tick(4);
  endtask

  task automatic run_frame(input logic [31:0] base, input int len, input int pitch,
                           input int lm1, input int bm, input string req);
    cfg_base = base; cfg_line_bytes = 16'(len); cfg_pitch = 16'(pitch);
    cfg_lines_m1 = 12'(lm1); cfg_burst = 5'(bm);
    build(base, len, pitch, lm1, bm);
    got_n = 0;
    pulse_sof();
    wait_n(exp_n);
    tick(10);
    compare(req);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(req_valid == 0, "R1 valid after reset", req_valid, 0);
    chk(bout == 0, "R1 nothing in flight", bout, 0);
  endtask

  task automatic t_split();
    run_frame(32'h1000, 40, 64, 2, 4, "R3 R4 R5 split");
    chk(got_beats[1] == 1, "R4 short tail burst", got_beats[1], 1);
    chk(got_addr[2] == 32'h1040, "R5 pitch step", got_addr[2], 32'h1040);
    chk(got_addr[0] == 32'h1000, "R2 first address", got_addr[0], 32'h1000);
    drain();
    run_frame(32'h3000, 20, 256, 1, 0, "R3 zero burst acts as one");
    drain();
    run_frame(32'h6000, 100, 128, 0, 20, "R3 R4 clamp and round up");
    chk(got_beats[0] == 13, "R4 13 beats in one burst", got_beats[0], 13);
    drain();
  endtask

  task automatic t_idle();
    run_frame(32'h7000, 16, 32, 1, 2, "R6 frame");
    tick(30);
    chk(got_n == 2, "R6 idle after last line", got_n, 2);
    chk(req_valid == 0, "R6 valid low when idle", req_valid, 0);
    drain();
  endtask

  task automatic t_outstanding();
    cfg_outstanding = 2; resp_en = 0; peak = 0;
    cfg_base = 32'h8000; cfg_line_bytes = 48; cfg_pitch = 64; cfg_lines_m1 = 1; cfg_burst = 2;
    build(32'h8000, 48, 64, 1, 2);
    got_n = 0;
    pulse_sof();
    tick(30);
    chk(got_n == 2, "R7 capped at two in flight", got_n, 2);
    chk(req_valid == 0, "R7 valid low at cap", req_valid, 0);
    resp_en = 1;
    wait_n(exp_n); tick(10);
    compare("R7 frame after responses");
    chk(peak <= 2, "R7 peak in flight", peak, 2);
    drain();
    cfg_outstanding = 4;
  endtask

  task automatic t_base_change();
    cfg_base = 32'h2000; cfg_line_bytes = 64; cfg_pitch = 128; cfg_lines_m1 = 3; cfg_burst = 2;
    build(32'h2000, 64, 128, 3, 2);
    got_n = 0;
    pulse_sof();
    wait_n(3);
    cfg_base = 32'h9000;
    wait_n(exp_n); tick(10);
    compare("R8 frame keeps old base");
    drain();
    got_n = 0;
    pulse_sof();
    wait_n(1);
    chk(got_addr[0] == 32'h9000, "R8 new base at next frame", got_addr[0], 32'h9000);
    drain();
  endtask

  task automatic t_stall();
    logic [31:0] a1; logic [4:0] b1;
    req_ready = 0;
    cfg_base = 32'h4000; cfg_line_bytes = 64; cfg_pitch = 64; cfg_lines_m1 = 1; cfg_burst = 4;
    got_n = 0;
    pulse_sof();
    tick(5);
    a1 = req_addr; b1 = req_beats;
    chk(req_valid == 1, "R9 valid raised while stalled", req_valid, 1);
    cfg_burst = 1;
    tick(3);
    chk(req_addr == a1 && req_beats == b1, "R9 request held", {req_addr, 3'b0, req_beats}, {a1, 3'b0, b1});
    chk(b1 == 4, "R9 held length", b1, 4);
    cfg_base = 32'h5000;
    pulse_sof();
    tick(3);
    chk(req_addr == 32'h4000, "R10 stalled request kept", req_addr, 32'h4000);
    req_ready = 1;
    wait_n(2); tick(1);
    chk(got_addr[0] == 32'h4000 && got_beats[0] == 4, "R10 old request first", got_addr[0], 32'h4000);
    chk(got_addr[1] == 32'h5000, "R10 restart at new base", got_addr[1], 32'h5000);
    drain();
  endtask

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    t_reset();
    t_split();
    t_idle();
    t_outstanding();
    t_base_change();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule